// File: doc/BRIEF.md
# Miss-Triggered Core Sleep Sequencer

This per-core controller lives beside the L1 cache controller and lets a core power down while one of its loads waits on a last-level-cache miss. L1 misses are recorded in an eight-entry outstanding-miss table. A miss notice from the shared last-level cache is acted on only if its address is in that table. When such a notice is accepted, the controller asks the checkpoint logic to save core state. Once the checkpoint is complete it enables sleep, so the checkpoint runs in the shadow of the stall.

The fill for the same address ends the episode. If the core is asleep, sleep is released and a one-cycle wakeup pulse is issued. The controller then waits for the restore to finish before it considers another sleep. If the fill arrives while the checkpoint is still running, the shutdown is dropped and the core carries on without sleeping. Every fill frees its table entry.

Top module: `miss_sleep_seq`

## Requirements
- R1: An L1 miss takes the lowest-numbered free entry of the 8-entry table. A miss whose address is already held, and not being filled in the same cycle, takes no entry. A miss that arrives while all 8 entries are held is dropped, so a later last-level notice for its address is ignored.
- R2: A last-level notice starts a sleep only when all of these hold: its address is held in the table, no fill for that address arrives in the same cycle, and the controller is neither checkpointing, asleep nor waking. Any other notice has no effect.
- R3: `shutdown_o` rises in the cycle after an accepted notice. It stays high until the checkpoint completes or the matching fill arrives.
- R4: `ckpt_done_i` seen while `shutdown_o` is high drops `shutdown_o` and raises `sleep_en_o` in the next cycle. `sleep_en_o` stays high until the fill for the sleeping address arrives.
- R5: A fill for the sleeping address while `shutdown_o` is high drops `shutdown_o` in the next cycle. `sleep_en_o` and `wakeup_o` are not raised, and this holds even if `ckpt_done_i` is asserted in the same cycle.
- R6: A fill for the sleeping address while `sleep_en_o` is high drops `sleep_en_o` in the next cycle. In that same next cycle, `wakeup_o` is high for exactly one cycle.
- R7: A fill for any other address while asleep leaves `sleep_en_o` high.
- R8: After a wakeup, last-level notices are ignored until `restore_done_i` is seen. From the cycle after that, notices are accepted again.
- R9: A fill frees the entry holding its address, so a later notice for that address is ignored.
- R10: During and after reset, all three outputs are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_miss_vld_i | input | 1 | L1 miss event |
| l1_miss_addr_i | input | ADDR_W | Line address of the L1 miss |
| llc_miss_vld_i | input | 1 | Last-level miss notice |
| llc_miss_addr_i | input | ADDR_W | Line address of the last-level miss |
| ckpt_done_i | input | 1 | Checkpoint of core state complete |
| fill_vld_i | input | 1 | Fill return event |
| fill_addr_i | input | ADDR_W | Line address of the fill |
| restore_done_i | input | 1 | Core state restore complete |
| shutdown_o | output | 1 | Shutdown request to the checkpoint logic |
| sleep_en_o | output | 1 | Core sleep enable |
| wakeup_o | output | 1 | One-cycle wakeup pulse |

## Verification
The bench checks the race between a fill and the checkpoint, including a fill that arrives in the same cycle as `ckpt_done_i`. A design that let the checkpoint win would put the core to sleep with its data already back, and the core would stay asleep with no fill left to wake it. The bench also sends notices for dropped, freed, unknown and same-cycle-filled addresses; a design that accepted any of them would raise `shutdown_o` for a load that is not stalled. It further checks that notices are ignored while waking, that a wrong-address fill does not wake the core, and that duplicate misses take no extra entries. Long random traffic over a small address set then stresses entry reuse against the model.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_LLC   = 3'd1,
    ST_CHECKPOINT = 3'd2,
    ST_ASLEEP     = 3'd3,
    ST_WAKING     = 3'd4
  } seq_state_e;
endpackage

// File: rtl/mss_miss_table.sv
module mss_miss_table #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_vld_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              fill_vld_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              probe_hit_o,
  output logic              occupied_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ENTRIES-1:0] alloc_match, fill_match, probe_match, alloc_oh;
  logic               alloc_dup, fill_same;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign alloc_match[i] = valid_q[i] && (addr_q[i] == alloc_addr_i);
    assign fill_match[i]  = valid_q[i] && fill_vld_i && (addr_q[i] == fill_addr_i);
    assign probe_match[i] = valid_q[i] && (addr_q[i] == probe_addr_i);
  end

  assign fill_same = fill_vld_i && (fill_addr_i == alloc_addr_i);
  assign alloc_dup = (|alloc_match) && !fill_same;

  // lowest free slot
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !found) begin
        alloc_oh[i] = alloc_vld_i && !alloc_dup;
        found       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      valid_q <= (valid_q & ~fill_match) | alloc_oh;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q[i] <= '0;
      else if (alloc_oh[i]) addr_q[i] <= alloc_addr_i;
    end
  end

  assign probe_hit_o = (|probe_match) && !(fill_vld_i && (fill_addr_i == probe_addr_i));
  assign occupied_o  = |valid_q;

  p_single_copy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(alloc_match) <= 1);
  p_fill_frees_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fill_match) && !(alloc_vld_i && fill_same) |=> !(|probe_match) || (probe_addr_i != $past(fill_addr_i)));
endmodule

// File: rtl/mss_sleep_fsm.sv
module mss_sleep_fsm
  import mss_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              llc_hit_i,
  input  logic [ADDR_W-1:0] llc_addr_i,
  input  logic              fill_vld_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              ckpt_done_i,
  input  logic              restore_done_i,
  input  logic              occupied_i,
  output logic              shutdown_o,
  output logic              sleep_en_o,
  output logic              wakeup_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] tgt_q;
  logic              wake_q, wake_d, tgt_fill, can_start;

  assign tgt_fill  = fill_vld_i && (fill_addr_i == tgt_q);
  assign can_start = (state_q == ST_IDLE) || (state_q == ST_WAIT_LLC);

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_WAIT_LLC: begin
        if (llc_hit_i)       state_d = ST_CHECKPOINT;
        else if (occupied_i) state_d = ST_WAIT_LLC;
        else                 state_d = ST_IDLE;
      end
      ST_CHECKPOINT: begin
        // fill beats checkpoint completion: abandon
        if (tgt_fill)         state_d = ST_IDLE;
        else if (ckpt_done_i) state_d = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        if (tgt_fill) begin
          state_d = ST_WAKING;
          wake_d  = 1'b1;
        end
      end
      ST_WAKING: begin
        if (restore_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wake_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
      if (can_start && llc_hit_i) tgt_q <= llc_addr_i;
    end
  end

  assign shutdown_o = (state_q == ST_CHECKPOINT);
  assign sleep_en_o = (state_q == ST_ASLEEP);
  assign wakeup_o   = wake_q;

  p_start_on_notice_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(llc_hit_i));
  p_sleep_after_ckpt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_en_o) |-> $past(shutdown_o && ckpt_done_i));
  p_abandon_no_sleep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o && tgt_fill |=> !sleep_en_o && !wakeup_o);
  p_wake_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_o |=> !wakeup_o);
  p_wake_from_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wakeup_o) |-> $past(sleep_en_o) && $fell(sleep_en_o));
  p_outputs_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({shutdown_o, sleep_en_o, wakeup_o}) <= 1);
endmodule

// File: rtl/miss_sleep_seq.sv
module miss_sleep_seq #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l1_miss_vld_i,
  input  logic [ADDR_W-1:0] l1_miss_addr_i,
  input  logic              llc_miss_vld_i,
  input  logic [ADDR_W-1:0] llc_miss_addr_i,
  input  logic              ckpt_done_i,
  input  logic              fill_vld_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              restore_done_i,
  output logic              shutdown_o,
  output logic              sleep_en_o,
  output logic              wakeup_o
);
  logic probe_hit, occupied, llc_hit;

  mss_miss_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_vld_i (l1_miss_vld_i),
    .alloc_addr_i(l1_miss_addr_i),
    .fill_vld_i  (fill_vld_i),
    .fill_addr_i (fill_addr_i),
    .probe_addr_i(llc_miss_addr_i),
    .probe_hit_o (probe_hit),
    .occupied_o  (occupied)
  );

  assign llc_hit = llc_miss_vld_i && probe_hit;

  mss_sleep_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .llc_hit_i     (llc_hit),
    .llc_addr_i    (llc_miss_addr_i),
    .fill_vld_i    (fill_vld_i),
    .fill_addr_i   (fill_addr_i),
    .ckpt_done_i   (ckpt_done_i),
    .restore_done_i(restore_done_i),
    .occupied_i    (occupied),
    .shutdown_o    (shutdown_o),
    .sleep_en_o    (sleep_en_o),
    .wakeup_o      (wakeup_o)
  );

  p_notice_needs_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(llc_miss_vld_i && occupied));
  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> !shutdown_o && !sleep_en_o && !wakeup_o);
endmodule

// File: tb/test_miss_sleep_seq.sv
module test_miss_sleep_seq;
  localparam int AW = 32;
  localparam int N  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l1_v = 0, llc_v = 0, ck = 0, fv = 0, rs = 0;
  logic [AW-1:0] l1_a = '0, llc_a = '0, fa = '0;
  logic sd, sl, wk;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  miss_sleep_seq #(.ENTRIES(N), .ADDR_W(AW)) i_miss_sleep_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .l1_miss_vld_i(l1_v), .l1_miss_addr_i(l1_a),
    .llc_miss_vld_i(llc_v), .llc_miss_addr_i(llc_a),
    .ckpt_done_i(ck), .fill_vld_i(fv), .fill_addr_i(fa),
    .restore_done_i(rs),
    .shutdown_o(sd), .sleep_en_o(sl), .wakeup_o(wk)
  );

  // reference model: 0 idle,1 wait,2 ckpt,3 asleep,4 waking
  bit          m_v [N];
  logic [AW-1:0] m_a [N];
  int          m_st = 0;
  logic [AW-1:0] m_tgt = '0;
  bit          m_wk = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_st = 0; m_wk = 0; m_tgt = '0;
    end else begin
      bit occ, hit, dup, tf, placed;
      bit nv [N];
      occ = 0; hit = 0; dup = 0;
      foreach (m_v[i]) begin
        if (m_v[i]) occ = 1;
        if (m_v[i] && m_a[i] == llc_a) hit = 1;
        if (m_v[i] && m_a[i] == l1_a) dup = 1;
      end
      if (fv && fa == llc_a) hit = 0;
      if (fv && fa == l1_a) dup = 0;
      hit = hit && llc_v;
      tf = fv && (fa == m_tgt);
      m_wk = 0;
      case (m_st)
        0, 1: if (hit) begin m_st = 2; m_tgt = llc_a; end
              else m_st = occ ? 1 : 0;
        2: if (tf) m_st = 0; else if (ck) m_st = 3;
        3: if (tf) begin m_st = 4; m_wk = 1; end
        4: if (rs) m_st = 0;
        default: m_st = 0;
      endcase
      foreach (m_v[i]) nv[i] = m_v[i] && !(fv && m_a[i] == fa);
      placed = 0;
      foreach (m_v[i]) if (!m_v[i] && !placed) begin
        placed = 1;
        if (l1_v && !dup) begin nv[i] = 1; m_a[i] = l1_a; end
      end
      foreach (m_v[i]) m_v[i] = nv[i];
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(sd, m_st == 2, "R3 shutdown_o vs model");
    chk(sl, m_st == 3, "R4 sleep_en_o vs model");
    chk(wk, m_wk,      "R6 wakeup_o vs model");
  end

  task automatic cyc(input logic a_l1v, input logic [AW-1:0] a_l1a,
                     input logic a_llcv, input logic [AW-1:0] a_llca,
                     input logic a_fv, input logic [AW-1:0] a_fa,
                     input logic a_ck, input logic a_rs);
    #1;
    l1_v = a_l1v; l1_a = a_l1a; llc_v = a_llcv; llc_a = a_llca;
    fv = a_fv; fa = a_fa; ck = a_ck; rs = a_rs;
    @(negedge clk);
  endtask

  task automatic nop();            cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic miss(input logic [AW-1:0] a);  cyc(1, a, 0, 0, 0, 0, 0, 0); endtask
  task automatic note(input logic [AW-1:0] a);  cyc(0, 0, 1, a, 0, 0, 0, 0); endtask
  task automatic fill(input logic [AW-1:0] a);  cyc(0, 0, 0, 0, 1, a, 0, 0); endtask
  task automatic ckd();            cyc(0, 0, 0, 0, 0, 0, 1, 0); endtask
  task automatic rsd();            cyc(0, 0, 0, 0, 0, 0, 0, 1); endtask

  task automatic expect3(input logic e_sd, input logic e_sl, input logic e_wk, input string tag);
    chk(sd, e_sd, {tag, " shutdown_o"});
    chk(sl, e_sl, {tag, " sleep_en_o"});
    chk(wk, e_wk, {tag, " wakeup_o"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect3(0, 0, 0, "R10 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect3(0, 0, 0, "R10 after reset");

    // full sleep and wake
    miss(32'hA0); note(32'hA0);
    expect3(1, 0, 0, "R3 accepted notice");
    nop();  expect3(1, 0, 0, "R3 held");
    ckd();  expect3(0, 1, 0, "R4 sleep after checkpoint");
    fill(32'hB0); expect3(0, 1, 0, "R7 other fill");
    fill(32'hA0); expect3(0, 0, 1, "R6 wake pulse");
    nop();  expect3(0, 0, 0, "R6 pulse one cycle");
    miss(32'hC0); note(32'hC0);
    expect3(0, 0, 0, "R8 notice while waking");
    rsd(); nop();
    note(32'hC0); expect3(1, 0, 0, "R8 accepted after restore");
    fill(32'hC0); expect3(0, 0, 0, "R5 abandon");
    ckd();  expect3(0, 0, 0, "R5 late ckpt_done");

    // fill and ckpt_done in same cycle
    miss(32'hD0); note(32'hD0);
    cyc(0, 0, 0, 0, 1, 32'hD0, 1, 0);
    expect3(0, 0, 0, "R5 same-cycle fill and done");
    nop(); expect3(0, 0, 0, "R5 no wake");

    note(32'hE0); expect3(0, 0, 0, "R2 unknown address");
    note(32'hD0); expect3(0, 0, 0, "R9 freed entry");
    miss(32'hF0);
    cyc(0, 0, 1, 32'hF0, 1, 32'hF0, 0, 0);
    expect3(0, 0, 0, "R2 same-cycle fill");

    // table capacity
    for (int i = 0; i < N; i++) miss(32'h100 + i);
    miss(32'h200);
    note(32'h200); expect3(0, 0, 0, "R1 dropped when full");
    note(32'h107); expect3(1, 0, 0, "R1 last entry held");
    fill(32'h107);
    fill(32'h100); fill(32'h101);
    miss(32'h100); miss(32'h100); fill(32'h100);
    note(32'h100); expect3(0, 0, 0, "R1 duplicate not allocated");
    for (int i = 2; i < 7; i++) fill(32'h100 + i);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom % 4) == 0, 32'($urandom % 12),
          ($urandom % 3) == 0, 32'($urandom % 12),
          ($urandom % 4) == 0, 32'($urandom % 12),
          ($urandom % 3) == 0, ($urandom % 3) == 0);
    end
    nop(); nop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule